// File: doc/BRIEF.md
# AXI Read/Write Same-ID Ordering Guard

This block sits on an AXI4 link between a traffic source and a memory slave. AXI gives no ordering between a read and a write, even when they carry the same ID. The guard adds that ordering. It keeps one counter of outstanding writes and one counter of outstanding reads for every ID. A new request is held back while a request with the same ID in the other direction is still incomplete.

A read is complete when its final data beat arrives. A write is complete when its write response arrives. Requests in the same direction with the same ID pass freely, because the slave already returns them in issue order.

On the write side, the guard keeps a short queue of accepted burst lengths. It uses that queue to release write data in address order and to mark the closing beat of every burst. The user side therefore never drives a last-beat flag. All valid, ready and payload paths are combinational, so the guard adds no cycles of latency. Responses pass straight through.

Top module: `axi_order_guard`

## Requirements
- R1: After reset no request is outstanding, so a write address with any ID is passed downstream at once (`m_awvalid` high, `s_awready` high while `m_awready` is high).
- R2: A read address whose ID has an outstanding write is blocked (`m_arvalid` and `s_arready` low) until the write response for that ID has been accepted.
- R3: A write address whose ID has an outstanding read is blocked until a read beat with `rlast`=1 and that ID has been accepted; beats with `rlast`=0 do not release it.
- R4: Requests whose ID has nothing outstanding in the other direction pass without delay.
- R5: A request passes while earlier requests with the same ID in the same direction are still outstanding.
- R6: When a write address and a read address with the same ID are presented in the same cycle and nothing is outstanding for that ID, the write passes and the read is blocked.
- R7: `m_wlast` is 1 on the beat with index `awlen` (counting from 0) of each burst and 0 on every other beat; for `awlen`=7 that is the eighth beat.
- R8: Write data is released only while an accepted write address has beats left. Bursts are closed in the order their addresses were accepted, and `m_wvalid` stays low while no address is pending.
- R9: Per-ID counters hold at most 15; while an ID has 15 outstanding requests in one direction, a further request with that ID in that direction is blocked until one completes.
- R10: While the burst-length queue (4 entries) is full, new write addresses are blocked; they pass again once a burst has been closed.
- R11: Once a downstream valid is high it stays high with a stable ID until its handshake. This holds even when a same-ID request in the other direction arrives in the meantime, and that request is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awid | input | 4 | User write ID |
| s_awaddr | input | 32 | User write address |
| s_awlen | input | 8 | User write burst length minus one |
| s_awvalid | input | 1 | User write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | User write data |
| s_wvalid | input | 1 | User write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bid | output | 4 | Write response ID |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | User ready for write response |
| s_arid | input | 4 | User read ID |
| s_araddr | input | 32 | User read address |
| s_arlen | input | 8 | User read burst length minus one |
| s_arvalid | input | 1 | User read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rid | output | 4 | Read data ID |
| s_rdata | output | 32 | Read data |
| s_rlast | output | 1 | Final read beat |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | User ready for read data |
| m_awid | output | 4 | Downstream write ID |
| m_awaddr | output | 32 | Downstream write address |
| m_awlen | output | 8 | Downstream write burst length minus one |
| m_awvalid | output | 1 | Downstream write address valid |
| m_awready | input | 1 | Slave ready for write address |
| m_wdata | output | 32 | Downstream write data |
| m_wlast | output | 1 | Final write beat of the burst |
| m_wvalid | output | 1 | Downstream write data valid |
| m_wready | input | 1 | Slave ready for write data |
| m_bid | input | 4 | Slave write response ID |
| m_bvalid | input | 1 | Slave write response valid |
| m_bready | output | 1 | Ready for write response |
| m_arid | output | 4 | Downstream read ID |
| m_araddr | output | 32 | Downstream read address |
| m_arlen | output | 8 | Downstream read burst length minus one |
| m_arvalid | output | 1 | Downstream read address valid |
| m_arready | input | 1 | Slave ready for read address |
| m_rid | input | 4 | Slave read data ID |
| m_rdata | input | 32 | Slave read data |
| m_rlast | input | 1 | Slave final read beat |
| m_rvalid | input | 1 | Slave read data valid |
| m_rready | output | 1 | Ready for read data |

## Verification
Pass and block decisions are combinational. They are therefore due in the same cycle a request is presented, and the bench reads them one time unit after it drives its inputs at the falling edge. Counter changes caused by a handshake, a write response or a closing read beat take effect at the next rising edge. The bench's stall checks are placed at the following falling edge for that reason. Expected last-beat flags are queued by the address driver, one per beat. The data driver pops one flag per beat it presents and compares it with `m_wlast` before the edge that completes the transfer.

// File: rtl/aog_otr_counters.sv
module aog_otr_counters #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 4,
  localparam int NUM_ID = 1 << ID_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           inc_i,
  input  logic [ID_W-1:0]                inc_id_i,
  input  logic                           dec_i,
  input  logic [ID_W-1:0]                dec_id_i,
  output logic [NUM_ID-1:0][CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < NUM_ID; g++) begin : g_id
    logic inc_hit, dec_hit;
    assign inc_hit = inc_i && (inc_id_i == ID_W'(g));
    assign dec_hit = dec_i && (dec_id_i == ID_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_o[g] <= '0;
      end else begin
        case ({inc_hit, dec_hit})
          2'b10:   cnt_o[g] <= cnt_o[g] + 1'b1;
          2'b01:   cnt_o[g] <= cnt_o[g] - 1'b1;
          default: cnt_o[g] <= cnt_o[g];
        endcase
      end
    end

    // R9: a new request is never let through onto a saturated counter
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_hit && !dec_hit) |-> (cnt_o[g] != CNT_MAX));
    // R2: completions only arrive for issued requests
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hit && !inc_hit) |-> (cnt_o[g] != '0));
  end
endmodule

// File: rtl/aog_len_fifo.sv
module aog_len_fifo #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pop_i,
  output logic [LEN_W-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [LEN_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (fill == '0);
  assign full_o  = (fill == CNT_W'(DEPTH));
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_i) wr_ptr <= ptr_next(wr_ptr);
      if (pop_i)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= len_i;
  end

  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/aog_wbeat.sv
module aog_wbeat #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] head_len_i,
  input  logic             beat_fire_i,
  output logic             last_o,
  output logic             burst_done_o
);
  logic [LEN_W-1:0] beat_idx;

  assign last_o       = (beat_idx == head_len_i);
  assign burst_done_o = beat_fire_i && last_o;

  always_ff @(posedge clk) begin
    if (!rst_n)            beat_idx <= '0;
    else if (burst_done_o) beat_idx <= '0;
    else if (beat_fire_i)  beat_idx <= beat_idx + 1'b1;
  end

  // R7: the beat index never runs past the burst length
  assert_idx_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire_i |-> (beat_idx <= head_len_i));
endmodule

// File: rtl/axi_order_guard.sv
module axi_order_guard #(
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 8,
  parameter int CNT_W      = 4,
  parameter int WLEN_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [ID_W-1:0]   s_bid,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [LEN_W-1:0]  s_arlen,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [ID_W-1:0]   s_rid,
  output logic [DATA_W-1:0] s_rdata,
  output logic              s_rlast,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   m_awid,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [LEN_W-1:0]  m_awlen,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [ID_W-1:0]   m_bid,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic [ID_W-1:0]   m_arid,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [LEN_W-1:0]  m_arlen,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [ID_W-1:0]   m_rid,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_rlast,
  input  logic              m_rvalid,
  output logic              m_rready
);
  localparam int NUM_ID = 1 << ID_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic cnt_busy(input logic [CNT_W-1:0] c);
    return c != '0;
  endfunction
  function automatic logic cnt_full(input logic [CNT_W-1:0] c);
    return c == CNT_MAX;
  endfunction

  logic [NUM_ID-1:0][CNT_W-1:0] wr_cnt, rd_cnt;
  logic aw_fire, ar_fire, w_fire, b_fire, rlast_fire;
  logic aw_block, ar_block, ar_pass, ar_held, same_id;
  logic wl_empty, wl_full, wl_pop, beat_last;
  logic [LEN_W-1:0] wl_head;

  // named events
  assign aw_fire    = m_awvalid && m_awready;
  assign ar_fire    = m_arvalid && m_arready;
  assign w_fire     = m_wvalid && m_wready;
  assign b_fire     = m_bvalid && s_bready;
  assign rlast_fire = m_rvalid && s_rready && m_rlast;
  assign same_id    = (s_awid == s_arid);

  // hazard decisions
  assign aw_block = cnt_busy(rd_cnt[s_awid]) || cnt_full(wr_cnt[s_awid]) || wl_full
                    || (ar_held && same_id);
  assign ar_block = cnt_busy(wr_cnt[s_arid]) || cnt_full(rd_cnt[s_arid])
                    || (s_awvalid && same_id);
  assign ar_pass  = ar_held || !ar_block;

  always_ff @(posedge clk) begin
    if (!rst_n) ar_held <= 1'b0;
    else        ar_held <= m_arvalid && !m_arready;
  end

  // address channels
  assign m_awid    = s_awid;
  assign m_awaddr  = s_awaddr;
  assign m_awlen   = s_awlen;
  assign m_awvalid = s_awvalid && !aw_block;
  assign s_awready = m_awready && !aw_block;

  assign m_arid    = s_arid;
  assign m_araddr  = s_araddr;
  assign m_arlen   = s_arlen;
  assign m_arvalid = s_arvalid && ar_pass;
  assign s_arready = m_arready && ar_pass;

  // write data channel
  assign m_wdata  = s_wdata;
  assign m_wvalid = s_wvalid && !wl_empty;
  assign s_wready = m_wready && !wl_empty;
  assign m_wlast  = beat_last;

  // response channels
  assign s_bid    = m_bid;
  assign s_bvalid = m_bvalid;
  assign m_bready = s_bready;
  assign s_rid    = m_rid;
  assign s_rdata  = m_rdata;
  assign s_rlast  = m_rlast;
  assign s_rvalid = m_rvalid;
  assign m_rready = s_rready;

  aog_otr_counters #(.ID_W(ID_W), .CNT_W(CNT_W)) u_wr_cnt (
    .clk(clk), .rst_n(rst_n),
    .inc_i(aw_fire), .inc_id_i(m_awid),
    .dec_i(b_fire),  .dec_id_i(m_bid),
    .cnt_o(wr_cnt)
  );

  aog_otr_counters #(.ID_W(ID_W), .CNT_W(CNT_W)) u_rd_cnt (
    .clk(clk), .rst_n(rst_n),
    .inc_i(ar_fire),    .inc_id_i(m_arid),
    .dec_i(rlast_fire), .dec_id_i(m_rid),
    .cnt_o(rd_cnt)
  );

  aog_len_fifo #(.DEPTH(WLEN_DEPTH), .LEN_W(LEN_W)) u_wlen (
    .clk(clk), .rst_n(rst_n),
    .push_i(aw_fire), .len_i(m_awlen), .pop_i(wl_pop),
    .head_o(wl_head), .empty_o(wl_empty), .full_o(wl_full)
  );

  aog_wbeat #(.LEN_W(LEN_W)) u_wbeat (
    .clk(clk), .rst_n(rst_n),
    .head_len_i(wl_head), .beat_fire_i(w_fire),
    .last_o(beat_last), .burst_done_o(wl_pop)
  );

  assert_ar_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |-> !cnt_busy(wr_cnt[m_arid]));
  assert_aw_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire |-> !cnt_busy(rd_cnt[m_awid]));
  assert_write_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_awvalid && s_arvalid && same_id && !ar_held
     && !cnt_busy(wr_cnt[s_awid]) && !cnt_busy(rd_cnt[s_awid])) |-> !m_arvalid);
  assert_ar_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_arid)));
  assert_aw_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awid)));
  assert_w_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> m_wvalid);
endmodule

// File: tb/axi_order_guard_bench.sv
module axi_order_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  s_awid = '0, s_arid = '0, m_bid = '0, m_rid = '0;
  logic [31:0] s_awaddr = '0, s_araddr = '0, s_wdata = '0, m_rdata = '0;
  logic [7:0]  s_awlen = '0, s_arlen = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic m_awready = 1, m_wready = 1, m_bvalid = 0, m_arready = 1, m_rlast = 0, m_rvalid = 0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rlast, s_rvalid;
  logic [3:0]  s_bid, s_rid, m_awid, m_arid;
  logic [31:0] s_rdata, m_awaddr, m_wdata, m_araddr;
  logic [7:0]  m_awlen, m_arlen;
  logic m_awvalid, m_wlast, m_wvalid, m_bready, m_arvalid, m_rready;

  axi_order_guard u_axi_order_guard (
    .clk, .rst_n,
    .s_awid, .s_awaddr, .s_awlen, .s_awvalid, .s_awready,
    .s_wdata, .s_wvalid, .s_wready,
    .s_bid, .s_bvalid, .s_bready,
    .s_arid, .s_araddr, .s_arlen, .s_arvalid, .s_arready,
    .s_rid, .s_rdata, .s_rlast, .s_rvalid, .s_rready,
    .m_awid, .m_awaddr, .m_awlen, .m_awvalid, .m_awready,
    .m_wdata, .m_wlast, .m_wvalid, .m_wready,
    .m_bid, .m_bvalid, .m_bready,
    .m_arid, .m_araddr, .m_arlen, .m_arvalid, .m_arready,
    .m_rid, .m_rdata, .m_rlast, .m_rvalid, .m_rready
  );

  int vecs = 0, errs = 0;
  bit exp_q[$];   // scoreboard of expected last-beat flags

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  // driver: write address; pushes one expected flag per beat when it passes
  task automatic aw_try(input logic [3:0] id, input logic [7:0] len, input bit pass, input string tag);
    @(negedge clk);
    s_awvalid = 1; s_awid = id; s_awlen = len; s_awaddr = {24'h0, id, 4'h0};
    #1;
    chk(tag, s_awready, pass);
    chk(tag, m_awvalid, pass);
    if (pass) begin
      for (int k = 0; k <= int'(len); k++) exp_q.push_back(k == int'(len));
      @(posedge clk); #1;
    end
    s_awvalid = 0;
  endtask

  task automatic ar_try(input logic [3:0] id, input bit pass, input string tag);
    @(negedge clk);
    s_arvalid = 1; s_arid = id; s_arlen = 8'd7; s_araddr = {24'h0, id, 4'h8};
    #1;
    chk(tag, s_arready, pass);
    chk(tag, m_arvalid, pass);
    if (pass) begin @(posedge clk); #1; end
    s_arvalid = 0;
  endtask

  // driver + monitor for write data: compares m_wlast against the scoreboard
  task automatic send_w(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_wvalid = 1; s_wdata = 32'(i);
      #1;
      chk("R8", m_wvalid, 1);
      if (exp_q.size() == 0) chk("R8 queue", 1, 0);
      else chk("R7", m_wlast, exp_q.pop_front());
      @(posedge clk); #1;
    end
    s_wvalid = 0;
  endtask

  task automatic r_beat(input logic [3:0] id, input bit last);
    @(negedge clk);
    m_rvalid = 1; m_rid = id; m_rlast = last;
    @(posedge clk); #1;
    m_rvalid = 0; m_rlast = 0;
  endtask

  task automatic b_resp(input logic [3:0] id);
    @(negedge clk);
    m_bvalid = 1; m_bid = id;
    @(posedge clk); #1;
    m_bvalid = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R8: data with no pending address is held
    @(negedge clk);
    s_wvalid = 1; #1;
    chk("R8", m_wvalid, 0);
    chk("R8", s_wready, 0);
    s_wvalid = 0;

    // R1 / R4: first write after reset passes
    aw_try(4'd3, 8'd7, 1, "R1");
    // R2: same-ID read blocked by outstanding write
    ar_try(4'd3, 0, "R2");
    // R4: other ID passes
    ar_try(4'd5, 1, "R4");
    // R7: eight-beat burst, last flag on the eighth
    send_w(8);

    // R3: same-ID write blocked by outstanding read, non-last beat keeps it
    aw_try(4'd5, 8'd3, 0, "R3");
    r_beat(4'd5, 0);
    aw_try(4'd5, 8'd3, 0, "R3");
    r_beat(4'd5, 1);
    aw_try(4'd5, 8'd3, 1, "R3");

    // R2: write response releases the read
    b_resp(4'd3);
    ar_try(4'd3, 1, "R2");

    // R6: simultaneous same-ID requests, write wins
    @(negedge clk);
    s_awvalid = 1; s_awid = 4'd9; s_awlen = 8'd0;
    s_arvalid = 1; s_arid = 4'd9;
    #1;
    chk("R6", m_awvalid, 1);
    chk("R6", m_arvalid, 0);
    chk("R6", s_arready, 0);
    exp_q.push_back(1'b1);
    @(posedge clk); #1;
    s_awvalid = 0; s_arvalid = 0;
    ar_try(4'd9, 0, "R2");

    // R5: same direction, same ID, while outstanding
    aw_try(4'd9, 8'd1, 1, "R5");
    ar_try(4'd3, 1, "R5");

    // R10: fill length queue (lengths 3,0,1,2), next write blocked
    aw_try(4'd12, 8'd2, 1, "R10");
    aw_try(4'd13, 8'd0, 0, "R10");
    // R8: bursts close in address order
    send_w(10);
    aw_try(4'd13, 8'd0, 1, "R10");
    send_w(1);

    // R9: counter saturation
    for (int i = 0; i < 15; i++) ar_try(4'd2, 1, "R9");
    ar_try(4'd2, 0, "R9");
    r_beat(4'd2, 1);
    ar_try(4'd2, 1, "R9");

    // R11: held read stays valid; late same-ID write is blocked
    @(negedge clk);
    m_arready = 0;
    s_arvalid = 1; s_arid = 4'd6;
    #1;
    chk("R11", m_arvalid, 1);
    @(negedge clk);
    s_awvalid = 1; s_awid = 4'd6; s_awlen = 8'd0;
    #1;
    chk("R11", m_arvalid, 1);
    chk("R11", m_arid, 6);
    chk("R11", m_awvalid, 0);
    m_arready = 1;
    @(posedge clk); #1;
    s_arvalid = 0;
    @(negedge clk); #1;
    chk("R3", m_awvalid, 0);
    s_awvalid = 0;

    chk("R7 queue drained", exp_q.size(), 0);
    finish_up();
  end
endmodule